// File: doc/BRIEF.md
# March C+ Memory Self-Test Engine

This block is a built-in self-test engine for one single-port synchronous RAM with a one-cycle read latency. While it is idle, the RAM's address, write data, write strobe and read strobe come straight from the functional logic. Raising `invoke` takes the engine out of reset and moves those four RAM inputs over to the engine. The engine then runs a fixed six-element march using two checkerboard backgrounds: 0x55-style (bit 0 set, alternating) and 0xAA-style (its complement). It checks every read against the value it expects, and raises `done` once the last compare has been made.

Two optional behaviours are set by level inputs. With `retention` high, the engine halts at the two points where a whole background has just been stored, which are the end of element 1 and the end of element 3. During the halt it does not touch the RAM and it raises `holdOut`. It waits there until `resume` is seen, and then carries on with the next element, whose first operation is a read. With `bitmapEn` high, `fail` no longer reports the sticky result. It gives a one-cycle pulse for each failing read, and `bitmapOut` shows the failing address, the element number and the bit-wise difference. A system integrator drives these pins from a test controller and reads the outputs afterwards.

Top module: `mbist_march`

## Requirements
- R1: While `invoke` is low, `memAddr`, `memWdata`, `memWe` and `memRe` equal `funcAddr`, `funcWdata`, `funcWe` and `funcRe`, and `done`, `fail`, `holdOut` and `bitmapOut` are all 0. Raising `invoke` starts the march again from element 1, address 0.
- R2: Element 1 issues one write per address in ascending order, from 0 to 2^ADDR_W-1. Each write stores the background P5, in which bit i is 1 when i is even. The engine issues at most one RAM operation per cycle and never a read and a write in the same cycle.
- R3: Elements 2 and 3 step through the addresses in ascending order. Element 2 does read P5, write PA, read PA at each address, where PA is the complement of P5. Element 3 does read PA, write P5, read P5. The three operations of an address take consecutive cycles.
- R4: Elements 4 and 5 step from address 2^ADDR_W-1 down to 0. Element 4 does read P5, write PA, read PA, and element 5 does read PA, write P5, read P5. Element 6 then steps down through the addresses with a single read of P5 at each.
- R5: Without retention pauses, the operations run back to back, 14·2^ADDR_W of them. `done` rises exactly two cycles after the cycle of the last read and stays high while `invoke` is high. No RAM operation is issued while `done` is high.
- R6: When every read returns the expected data, `fail` stays 0 for the whole run.
- R7: When `bitmapEn` is low, `fail` becomes 1 two cycles after a read whose data differs from the expected value. It then stays 1 until `invoke` goes low. Failures seen while `bitmapEn` is high also set this sticky flag, and it shows on `fail` once `bitmapEn` goes low.
- R8: When `bitmapEn` is high, `fail` pulses high for exactly one cycle, two cycles after each failing read. In that same cycle `bitmapOut` holds {address [ADDR_W-1:0], element number 1..6 [2:0], expected XOR actual [DATA_W-1:0]}, with the address in the most significant field. When `bitmapEn` is low, `bitmapOut` is 0.
- R9: When `retention` is high in the cycle the last operation of element 1 or element 3 is issued, the engine enters a pause in the next cycle. `holdOut` is 1 throughout the pause and no RAM operation is issued. In the cycle after `resume` is seen high during the pause, the engine issues the first read of the next element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| invoke | input | 1 | Claims the RAM for test and releases the engine from reset |
| retention | input | 1 | Requests pauses after elements 1 and 3 |
| resume | input | 1 | Ends a retention pause |
| bitmapEn | input | 1 | Selects per-read failure reporting |
| funcAddr | input | ADDR_W | Functional address |
| funcWdata | input | DATA_W | Functional write data |
| funcWe | input | 1 | Functional write strobe |
| funcRe | input | 1 | Functional read strobe |
| memRdata | input | DATA_W | RAM read data, one cycle after the read |
| memAddr | output | ADDR_W | RAM address |
| memWdata | output | DATA_W | RAM write data |
| memWe | output | 1 | RAM write strobe |
| memRe | output | 1 | RAM read strobe |
| done | output | 1 | March finished |
| fail | output | 1 | Sticky failure, or per-read pulse in bitmap mode |
| holdOut | output | 1 | Retention pause in progress |
| bitmapOut | output | ADDR_W+3+DATA_W | Failure record in bitmap mode |

## Verification
The march is run against a fault-free RAM and against RAMs with a single cell bit stuck at 0 or at 1. The faults are placed on even and odd bit positions and on the lowest, a middle and the highest address. Because of this, the P5 and PA reads catch different faults, and the number of failing reads (five or four) shows whether the expected value was taken from the right background in each element. Every run checks the complete operation stream cycle by cycle, so an error in address direction, operation order or data background shows up. Runs with `retention` set check that the engine pauses exactly twice and resumes with a read. Runs with `bitmapEn` set check every reported address, element and difference field, and then check that the sticky flag appears when bitmap mode is left.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int ELEM_W = 3;
  localparam int NUM_ELEM = 6;
  localparam int FIRST_DOWN = 3;
  localparam int PAUSE_A = 0;
  localparam int PAUSE_B = 2;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_HOLD,
    ST_FINISH,
    ST_DONE
  } bistState_t;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic              dataA;
    logic              addrStep;
    logic              stepDown;
    logic              loadUp;
    logic              loadDown;
    logic [ELEM_W-1:0] elem;
  } bistStrobe_t;
endpackage

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        invoke,
  input  logic        retention,
  input  logic        resume,
  input  logic        atTop,
  input  logic        atBottom,
  output bistStrobe_t strb,
  output logic        holdState,
  output logic        doneState
);
  localparam logic [ELEM_W-1:0] LAST_ELEM  = ELEM_W'(NUM_ELEM - 1);
  localparam logic [ELEM_W-1:0] DOWN_ELEM  = ELEM_W'(FIRST_DOWN);
  localparam logic [ELEM_W-1:0] PAUSE_EL_A = ELEM_W'(PAUSE_A);
  localparam logic [ELEM_W-1:0] PAUSE_EL_B = ELEM_W'(PAUSE_B);

  bistState_t        state;
  logic [ELEM_W-1:0] elem;
  logic [1:0]        opIdx;
  logic              singleOp;
  logic              lastOp;
  logic              stepDown;
  logic              addrAtEnd;
  logic              active;
  logic              elemEnd;
  logic              bgIsA;

  always_comb begin
    singleOp  = (elem == '0) || (elem == LAST_ELEM);
    lastOp    = singleOp || (opIdx == 2'd2);
    stepDown  = (elem >= DOWN_ELEM);
    addrAtEnd = stepDown ? atBottom : atTop;
    active    = (state == ST_RUN);
    elemEnd   = active && lastOp && addrAtEnd;
    bgIsA     = (elem == 3'd2) || (elem == 3'd4);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
      elem  <= '0;
      opIdx <= '0;
    end else if (!invoke) begin
      state <= ST_RUN;
      elem  <= '0;
      opIdx <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (lastOp) begin
            opIdx <= '0;
            if (addrAtEnd) begin
              if (elem == LAST_ELEM) begin
                state <= ST_FINISH;
              end else begin
                elem <= elem + 3'd1;
                if (retention && (elem == PAUSE_EL_A || elem == PAUSE_EL_B))
                  state <= ST_HOLD;
              end
            end
          end else begin
            opIdx <= opIdx + 2'd1;
          end
        end
        ST_HOLD:   if (resume) state <= ST_RUN;
        ST_FINISH: state <= ST_DONE;
        default:   state <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.elem     = elem;
    strb.stepDown = stepDown;
    if (active) begin
      if (elem == '0) begin
        strb.wr = 1'b1;
      end else if (elem == LAST_ELEM) begin
        strb.rd = 1'b1;
      end else begin
        strb.wr    = (opIdx == 2'd1);
        strb.rd    = (opIdx != 2'd1);
        strb.dataA = bgIsA ^ (opIdx != 2'd0);
      end
      strb.addrStep = lastOp && !addrAtEnd;
      strb.loadUp   = elemEnd && (elem < PAUSE_EL_B);
      strb.loadDown = elemEnd && (elem >= PAUSE_EL_B) && (elem != LAST_ELEM);
    end
  end

  assign holdState = (state == ST_HOLD);
  assign doneState = (state == ST_DONE);
endmodule

// File: rtl/mbist_dp.sv
module mbist_dp
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         invoke,
  input  logic                         bitmapEn,
  input  bistStrobe_t                  strb,
  input  logic [DATA_W-1:0]            memRdata,
  output logic [ADDR_W-1:0]            bistAddr,
  output logic [DATA_W-1:0]            bistWdata,
  output logic                         bistWe,
  output logic                         bistRe,
  output logic                         atTop,
  output logic                         atBottom,
  output logic                         failSticky,
  output logic                         failPulse,
  output logic [ADDR_W+ELEM_W+DATA_W-1:0] bitmapReg
);
  logic [DATA_W-1:0] pat5;
  logic [DATA_W-1:0] patA;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bg
    assign pat5[b] = ((b % 2) == 0);
    assign patA[b] = ((b % 2) != 0);
  end

  logic              cmpValid;
  logic [DATA_W-1:0] cmpExp;
  logic [ADDR_W-1:0] cmpAddr;
  logic [ELEM_W-1:0] cmpElem;
  logic [DATA_W-1:0] diff;
  logic              mismatch;

  assign bistWdata = strb.dataA ? patA : pat5;
  assign bistWe    = strb.wr;
  assign bistRe    = strb.rd;
  assign atTop     = (bistAddr == '1);
  assign atBottom  = (bistAddr == '0);
  assign diff      = memRdata ^ cmpExp;
  assign mismatch  = cmpValid && (diff != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bistAddr <= '0;
    end else if (!invoke || strb.loadUp) begin
      bistAddr <= '0;
    end else if (strb.loadDown) begin
      bistAddr <= '1;
    end else if (strb.addrStep) begin
      bistAddr <= strb.stepDown ? bistAddr - 1'b1 : bistAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpValid <= 1'b0;
      cmpExp   <= '0;
      cmpAddr  <= '0;
      cmpElem  <= '0;
    end else begin
      cmpValid <= invoke && strb.rd;
      cmpExp   <= bistWdata;
      cmpAddr  <= bistAddr;
      cmpElem  <= strb.elem;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failSticky <= 1'b0;
      failPulse  <= 1'b0;
      bitmapReg  <= '0;
    end else if (!invoke) begin
      failSticky <= 1'b0;
      failPulse  <= 1'b0;
      bitmapReg  <= '0;
    end else begin
      failSticky <= failSticky || mismatch;
      failPulse  <= mismatch && bitmapEn;
      if (mismatch && bitmapEn)
        bitmapReg <= {cmpAddr, cmpElem + 3'd1, diff};
    end
  end
endmodule

// File: rtl/mbist_march.sv
module mbist_march
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            invoke,
  input  logic                            retention,
  input  logic                            resume,
  input  logic                            bitmapEn,
  input  logic [ADDR_W-1:0]               funcAddr,
  input  logic [DATA_W-1:0]               funcWdata,
  input  logic                            funcWe,
  input  logic                            funcRe,
  input  logic [DATA_W-1:0]               memRdata,
  output logic [ADDR_W-1:0]               memAddr,
  output logic [DATA_W-1:0]               memWdata,
  output logic                            memWe,
  output logic                            memRe,
  output logic                            done,
  output logic                            fail,
  output logic                            holdOut,
  output logic [ADDR_W+ELEM_W+DATA_W-1:0] bitmapOut
);
  bistStrobe_t                     strb;
  logic                            atTop;
  logic                            atBottom;
  logic                            holdState;
  logic                            doneState;
  logic [ADDR_W-1:0]               bistAddr;
  logic [DATA_W-1:0]               bistWdata;
  logic                            bistWe;
  logic                            bistRe;
  logic                            failSticky;
  logic                            failPulse;
  logic [ADDR_W+ELEM_W+DATA_W-1:0] bitmapReg;

  mbist_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .invoke    (invoke),
    .retention (retention),
    .resume    (resume),
    .atTop     (atTop),
    .atBottom  (atBottom),
    .strb      (strb),
    .holdState (holdState),
    .doneState (doneState)
  );

  mbist_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .invoke     (invoke),
    .bitmapEn   (bitmapEn),
    .strb       (strb),
    .memRdata   (memRdata),
    .bistAddr   (bistAddr),
    .bistWdata  (bistWdata),
    .bistWe     (bistWe),
    .bistRe     (bistRe),
    .atTop      (atTop),
    .atBottom   (atBottom),
    .failSticky (failSticky),
    .failPulse  (failPulse),
    .bitmapReg  (bitmapReg)
  );

  assign memAddr   = invoke ? bistAddr  : funcAddr;
  assign memWdata  = invoke ? bistWdata : funcWdata;
  assign memWe     = invoke ? bistWe    : funcWe;
  assign memRe     = invoke ? bistRe    : funcRe;
  assign done      = invoke && doneState;
  assign holdOut   = invoke && holdState;
  assign fail      = invoke && (bitmapEn ? failPulse : failSticky);
  assign bitmapOut = (invoke && bitmapEn) ? bitmapReg : '0;
endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk (
  input logic clk,
  input logic rstN,
  input logic invoke,
  input logic resume,
  input logic bitmapEn,
  input logic memWe,
  input logic memRe,
  input logic done,
  input logic fail,
  input logic holdOut
);
  a_r2_one_op: assert property (@(posedge clk) disable iff (!rstN)
    invoke |-> !(memWe && memRe));

  a_r5_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!memWe && !memRe));

  a_r5_done_stays: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (done || !invoke));

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (fail && invoke && !bitmapEn) |=> (fail || !invoke || bitmapEn));

  a_r9_hold_quiet: assert property (@(posedge clk) disable iff (!rstN)
    holdOut |-> (!memWe && !memRe));

  a_r9_hold_until_resume: assert property (@(posedge clk) disable iff (!rstN)
    (holdOut && !resume) |=> (holdOut || !invoke));
endmodule

bind mbist_march mbist_march_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .invoke   (invoke),
  .resume   (resume),
  .bitmapEn (bitmapEn),
  .memWe    (memWe),
  .memRe    (memRe),
  .done     (done),
  .fail     (fail),
  .holdOut  (holdOut)
);

// File: tb/mbist_march_tb_top.sv
module mbist_march_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NOPS = 14 * DEPTH;
  localparam int BM_W = ADDR_W + 3 + DATA_W;
  localparam int NSCEN = 6;
  // columns: faultEn, faultAddr, faultBit, faultVal, bitmap, retention, expFails, expHolds
  localparam int SCEN [NSCEN][8] = '{
    '{0,  0, 0, 0, 0, 0, 0, 0},
    '{1,  0, 0, 0, 0, 0, 5, 0},
    '{1,  7, 3, 0, 1, 0, 4, 0},
    '{1, 15, 2, 1, 1, 1, 4, 2},
    '{0,  0, 0, 0, 0, 1, 0, 2},
    '{1, 15, 7, 1, 1, 0, 5, 0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic invoke = 1'b0, retention = 1'b0, resume = 1'b0, bitmapEn = 1'b0;
  logic [ADDR_W-1:0] funcAddr = '0;
  logic [DATA_W-1:0] funcWdata = '0;
  logic funcWe = 1'b0, funcRe = 1'b0;
  logic [DATA_W-1:0] memRdata;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic memWe, memRe, done, fail, holdOut;
  logic [BM_W-1:0] bitmapOut;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbist_march #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .invoke(invoke), .retention(retention),
    .resume(resume), .bitmapEn(bitmapEn), .funcAddr(funcAddr),
    .funcWdata(funcWdata), .funcWe(funcWe), .funcRe(funcRe),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRe(memRe), .done(done), .fail(fail),
    .holdOut(holdOut), .bitmapOut(bitmapOut)
  );

  // behavioural RAM with one injectable stuck-at cell bit
  logic [DATA_W-1:0] ram [DEPTH];
  logic faultEn = 1'b0;
  logic [ADDR_W-1:0] faultAddr = '0;
  int faultBit = 0;
  logic faultVal = 1'b0;

  always_ff @(posedge clk) begin
    if (memWe) ram[memAddr] <= memWdata;
    if (memRe) begin
      if (faultEn && memAddr == faultAddr) begin
        memRdata <= ram[memAddr];
        memRdata[faultBit] <= faultVal;
      end else begin
        memRdata <= ram[memAddr];
      end
    end
  end

  // expected operation stream, built from R2..R4
  logic              sWe   [NOPS];
  logic [ADDR_W-1:0] sAddr [NOPS];
  logic [DATA_W-1:0] sData [NOPS];
  int                sElem [NOPS];
  logic [DATA_W-1:0] p5, pA;

  task automatic buildStream();
    int k = 0;
    for (int b = 0; b < DATA_W; b++) p5[b] = (b % 2 == 0);
    pA = ~p5;
    for (int i = 0; i < DEPTH; i++) begin
      sWe[k] = 1; sAddr[k] = ADDR_W'(i); sData[k] = p5; sElem[k] = 1; k++;
    end
    for (int e = 2; e <= 5; e++) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [DATA_W-1:0] bg;
        logic [ADDR_W-1:0] a;
        a  = (e <= 3) ? ADDR_W'(i) : ADDR_W'(DEPTH - 1 - i);
        bg = (e == 3 || e == 5) ? pA : p5;
        sWe[k] = 0; sAddr[k] = a; sData[k] = bg;  sElem[k] = e; k++;
        sWe[k] = 1; sAddr[k] = a; sData[k] = ~bg; sElem[k] = e; k++;
        sWe[k] = 0; sAddr[k] = a; sData[k] = ~bg; sElem[k] = e; k++;
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      sWe[k] = 0; sAddr[k] = ADDR_W'(DEPTH - 1 - i); sData[k] = p5; sElem[k] = 6; k++;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive();
    @(posedge clk);
    #1;
  endtask

  task automatic checkIdle(input string tag);
    @(negedge clk);
    chk(memAddr == funcAddr && memWdata == funcWdata && memWe == funcWe && memRe == funcRe,
        "R1", {tag, " passthrough"}, {memAddr, memWdata, memWe, memRe},
        {funcAddr, funcWdata, funcWe, funcRe});
    chk(!done && !fail && !holdOut && bitmapOut == '0, "R1", {tag, " outputs zero"},
        {done, fail, holdOut, bitmapOut}, 0);
  endtask

  task automatic runScen(input int s);
    int k = 0, cyc = 0, lastAcc = -1, doneCyc = -1;
    int pulses = 0, holdEntries = 0, holdCnt = 0;
    int expFails = SCEN[s][6];
    int pulseElem [16];
    int nPulse = 0;
    bit bm = (SCEN[s][4] != 0);
    bit prevHold = 0;
    faultEn   = (SCEN[s][0] != 0);
    faultAddr = ADDR_W'(SCEN[s][1]);
    faultBit  = SCEN[s][2];
    faultVal  = (SCEN[s][3] != 0);
    for (int i = 0; i < NOPS; i++)
      if (faultEn && !sWe[i] && sAddr[i] == faultAddr && sData[i][faultBit] != faultVal) begin
        if (nPulse < 16) pulseElem[nPulse] = sElem[i];
        nPulse++;
      end
    chk(nPulse == expFails, "R8", "table fail count", nPulse, expFails);
    for (int i = 0; i < DEPTH; i++) ram[i] = '0;
    drive();
    bitmapEn  = bm;
    retention = (SCEN[s][5] != 0);
    invoke    = 1'b1;
    while (doneCyc < 0 && cyc < 4000) begin
      @(negedge clk);
      if (memWe || memRe) begin
        if (k < NOPS) begin
          chk(memWe == sWe[k] && memRe == !sWe[k] && memAddr == sAddr[k] && (!sWe[k] || memWdata == sData[k]),
              sElem[k] <= 1 ? "R2" : (sElem[k] <= 3 ? "R3" : "R4"), "operation stream",
              {memWe, memRe, memAddr, memWdata}, {sWe[k], !sWe[k], sAddr[k], sData[k]});
          if (prevHold) chk(!memWe, "R9", "first op after resume is a read", memWe, 0);
        end else begin
          chk(0, "R5", "extra operation", k, NOPS);
        end
        lastAcc = cyc;
        k++;
      end
      if (holdOut && !prevHold) holdEntries++;
      if (holdOut) chk(!memWe && !memRe, "R9", "no access in pause", {memWe, memRe}, 0);
      prevHold = holdOut;
      if (bm && fail) begin
        chk(bitmapOut[DATA_W+3 +: ADDR_W] == faultAddr, "R8", "bitmap address",
            bitmapOut[DATA_W+3 +: ADDR_W], faultAddr);
        chk(bitmapOut[DATA_W-1:0] == DATA_W'(1) << faultBit, "R8", "bitmap difference",
            bitmapOut[DATA_W-1:0], DATA_W'(1) << faultBit);
        if (pulses < 16 && pulses < nPulse)
          chk(int'(bitmapOut[DATA_W +: 3]) == pulseElem[pulses], "R8", "bitmap element",
              bitmapOut[DATA_W +: 3], pulseElem[pulses]);
        pulses++;
      end
      if (!bm) chk(bitmapOut == '0, "R8", "bitmap idle when disabled", bitmapOut, 0);
      if (!faultEn) chk(!fail, "R6", "no fail on clean RAM", fail, 0);
      if (done) doneCyc = cyc;
      holdCnt = holdOut ? holdCnt + 1 : 0;
      drive();
      resume = (holdCnt == 4);
      cyc++;
    end
    chk(k == NOPS, "R5", "operation count", k, NOPS);
    chk(doneCyc == lastAcc + 2, "R5", "done timing", doneCyc, lastAcc + 2);
    chk(holdEntries == SCEN[s][7], "R9", "pause count", holdEntries, SCEN[s][7]);
    if (bm) chk(pulses == expFails, "R8", "fail pulse count", pulses, expFails);
    else    chk(fail == (expFails > 0), "R7", "sticky fail at done", fail, expFails > 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(done && !memWe && !memRe, "R5", "done holds, RAM idle", {done, memWe, memRe}, 3'b100);
      if (!bm) chk(fail == (expFails > 0), "R7", "fail stays", fail, expFails > 0);
    end
    if (bm) begin
      drive();
      bitmapEn = 1'b0;
      @(negedge clk);
      chk(fail == (expFails > 0), "R7", "sticky visible after bitmap", fail, expFails > 0);
    end
    drive();
    invoke = 1'b0;
    bitmapEn = 1'b0;
    retention = 1'b0;
    resume = 1'b0;
    funcAddr = ADDR_W'(s + 3);
    funcWdata = DATA_W'(8'h3C + s);
    funcWe = s[0];
    funcRe = !s[0];
    checkIdle("after run");
    drive();
    funcWe = 1'b0;
    funcRe = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R5 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    buildStream();
    funcAddr = 4'h9;
    funcWdata = 8'h12;
    funcWe = 1'b1;
    #1;
    chk(!done && !fail && !holdOut && bitmapOut == '0, "R1", "reset state", {done, fail, holdOut}, 0);
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    checkIdle("idle write");
    drive();
    funcWe = 1'b0;
    funcRe = 1'b1;
    funcAddr = 4'h2;
    checkIdle("idle read");
    // abort part-way, then a full run must restart from element 1 address 0
    drive();
    invoke = 1'b1;
    repeat (40) @(posedge clk);
    #1;
    invoke = 1'b0;
    checkIdle("abort");
    for (int s = 0; s < NSCEN; s++) runScen(s);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule